// File: doc/BRIEF.md
# Configurable General-Purpose Timer Channel

This block is one channel of a timer bank. Software programs it through a 16-bit control word and a reload value, and reads back the control word, the reload value and the live count. The count advances on one of several sources:

- the CPU clock divided by a power of two from 1 to 64;
- rising edges of an external event pin;
- the terminal-count pulse of the next lower channel, so that two channels act as one longer counter.

An external gate pin can restrict counting to periods when it is low, or to periods when it is high. A debug-halt input can freeze the count.

The channel counts up or down over either a narrow width or a wide width. When it steps past its terminal value it emits a one-cycle terminal pulse. It then either reloads or holds and stops. If interrupts are enabled, the step also sets a sticky interrupt flag, which stays set until software writes the clear bit. A pulse-driven chain is built by connecting `tc_o` of one channel to `lower_tc_i` of the next.

Top module: `tmr_channel`

## Requirements
- R1: After a synchronous reset, `count_o`, `ctrl_o`, `reload_o`, `tc_o` and `irq_o` are all zero.
- R2: The control word uses these fields:
  - bit 15: run;
  - bit 10: debug freeze;
  - bit 9: interrupt clear (write-only, always reads 0);
  - bits 8:6: clock select;
  - bits 5:4: mode;
  - bit 3: interrupt enable;
  - bit 2: direction (1 = down);
  - bit 1: width (1 = wide);
  - bit 0: auto-reload.

  Bits 14:11 read as 0. `reload_o` returns the low `WIDE_W` bits that were written.
- R3: A write that changes bit 15 from 0 to 1 loads the count. The count becomes the reload value (masked to the selected width) when counting down, and 0 when counting up. While bit 15 is 0, the count does not change.
- R4: For clock-select codes 0 to 6, the count advances once every 2^code clock cycles. The first advance comes 2^code cycles after the enabling write.
- R5: Clock-select code 7 makes the count advance once per rising edge of `ext_event_i`. A level held high gives only one advance.
- R6: Mode 1 counts only while `ext_gate_i` is low, and mode 2 counts only while it is high. The gate passes through a two-flop synchronizer.
- R7: Counting down, the terminal step is the step taken from 0. Counting up, it is the step taken from all-ones at the selected width.
- R8: In narrow mode (bit 1 = 0), the count and the loaded reload value are confined to the low `NARROW_W` bits.
- R9: At the terminal step with auto-reload set, the count loads the reload value. Without auto-reload, the count holds its terminal value and stays stopped until it is re-enabled.
- R10: `tc_o` is high for exactly the one cycle that follows each terminal step.
- R11: `irq_o` is set on a terminal step when bit 3 is 1, and it stays set until a control write with bit 9 = 1 occurs. If a set and a clear happen in the same cycle, the clear wins.
- R12: In mode 3, the count advances once per cycle in which `lower_tc_i` is high, and the clock-select field is ignored.
- R13: With bit 10 = 1, the count does not advance in cycles where `dbg_halt_i` is high. With bit 10 = 0, `dbg_halt_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| reload_we | input | 1 | Write strobe for the reload value |
| wdata | input | BUS_W | Write data |
| ext_event_i | input | 1 | External event pin (asynchronous) |
| ext_gate_i | input | 1 | External gate pin (asynchronous) |
| dbg_halt_i | input | 1 | CPU in debug state |
| lower_tc_i | input | 1 | Terminal pulse from the lower channel |
| ctrl_o | output | 16 | Control word readback |
| reload_o | output | WIDE_W | Reload value readback |
| count_o | output | WIDE_W | Live count |
| tc_o | output | 1 | One-cycle terminal-count pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench uses a small configuration with a 4-bit narrow width and an 8-bit wide width, so that every wrap point can be reached. It sweeps all seven divide codes. For each code it samples the cycle just before the first advance, the cycle of the first advance, and a long run; this separates an off-by-one in the divider phase from a wrong divide ratio.

Several runs are traced cycle by cycle:
- down counting with reload, which shows the terminal step from 0;
- up counting with and without reload, which shows hold versus reload;
- a reload value wider than the narrow width, which shows masking.

Gate, event, chain and debug stimuli each use a known number of active cycles or pulses. A final count that is short or long shows whether the source was qualified correctly. A clear written on the exact cycle of a terminal step exposes whether the interrupt clear takes priority over the set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Bit positions in the control word. These are decoded by software, so they are fixed.
  localparam int unsigned CTL_RUN   = 15;
  localparam int unsigned CTL_DBGF  = 10;
  localparam int unsigned CTL_CLR   = 9;
  localparam int unsigned CTL_SEL_H = 8;
  localparam int unsigned CTL_SEL_L = 6;
  localparam int unsigned CTL_MOD_H = 5;
  localparam int unsigned CTL_MOD_L = 4;
  localparam int unsigned CTL_IEN   = 3;
  localparam int unsigned CTL_DOWN  = 2;
  localparam int unsigned CTL_WIDE  = 1;
  localparam int unsigned CTL_RLD   = 0;

  localparam int unsigned SEL_W     = 3;
  localparam int unsigned DIV_CODES = 7;              // codes 0..6 select a divided clock
  localparam int unsigned PRE_W     = DIV_CODES - 1;  // largest divide is 2^PRE_W
  localparam logic [SEL_W-1:0] SEL_EXT = 3'd7;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_GATE_LO = 2'd1,
    MODE_GATE_HI = 2'd2,
    MODE_CHAIN   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic             run;
    logic             dbg_freeze;
    logic [SEL_W-1:0] clk_sel;
    tmr_mode_e        mode;
    logic             irq_en;
    logic             count_down;
    logic             wide;
    logic             auto_reload;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t ctrl_decode(input logic [15:0] w);
    tmr_ctrl_t c;
    c.run         = w[CTL_RUN];
    c.dbg_freeze  = w[CTL_DBGF];
    c.clk_sel     = w[CTL_SEL_H:CTL_SEL_L];
    c.mode        = tmr_mode_e'(w[CTL_MOD_H:CTL_MOD_L]);
    c.irq_en      = w[CTL_IEN];
    c.count_down  = w[CTL_DOWN];
    c.wide        = w[CTL_WIDE];
    c.auto_reload = w[CTL_RLD];
    return c;
  endfunction

  function automatic logic [15:0] ctrl_encode(input tmr_ctrl_t c);
    logic [15:0] w;
    w = '0;
    w[CTL_RUN]             = c.run;
    w[CTL_DBGF]            = c.dbg_freeze;
    w[CTL_SEL_H:CTL_SEL_L] = c.clk_sel;
    w[CTL_MOD_H:CTL_MOD_L] = c.mode;
    w[CTL_IEN]             = c.irq_en;
    w[CTL_DOWN]            = c.count_down;
    w[CTL_WIDE]            = c.wide;
    w[CTL_RLD]             = c.auto_reload;
    return w;
  endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned N_SEL = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] div_mask [N_SEL];

  // One mask per code: the low 'code' bits are set; the external code gets no mask.
  for (genvar g = 0; g < N_SEL; g++) begin : g_mask
    if (g < DIV_CODES) begin : g_div
      assign div_mask[g] = PRE_W'((1 << g) - 1);
    end else begin : g_none
      assign div_mask[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 1'b1;
  end

  assign tick = (sel != SEL_EXT) && ((pre_q & div_mask[sel]) == div_mask[sel]);

  // R4: when the divider is cleared, the phase counter restarts from zero
  a_r4_phase_restart: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pre_q == '0));
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  tmr_ctrl_t        ctrl,
  input  logic             pre_tick,
  input  logic             ext_s,
  input  logic             gate_s,
  input  logic             lower_tc,
  input  logic             dbg_halt,
  output logic             step
);
  logic ext_d;
  logic ext_rise;
  logic src;
  logic gate_ok;
  logic frozen;

  always_ff @(posedge clk) begin
    if (rst) ext_d <= 1'b0;
    else     ext_d <= ext_s;
  end

  assign ext_rise = ext_s & ~ext_d;

  always_comb begin
    if (ctrl.mode == MODE_CHAIN)     src = lower_tc;
    else if (ctrl.clk_sel == SEL_EXT) src = ext_rise;
    else                             src = pre_tick;
  end

  always_comb begin
    unique case (ctrl.mode)
      MODE_GATE_LO: gate_ok = ~gate_s;
      MODE_GATE_HI: gate_ok = gate_s;
      default:      gate_ok = 1'b1;
    endcase
  end

  assign frozen = ctrl.dbg_freeze & dbg_halt;
  assign step   = ctrl.run & src & gate_ok & ~frozen;

  // R5: a synchronized level that stays high gives no second event
  a_r5_single_event: assert property (@(posedge clk) disable iff (rst)
    (ext_s && $past(ext_s)) |-> !ext_rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  input  logic              load_down,
  input  logic              load_wide,
  input  logic              step,
  input  logic              count_down,
  input  logic              wide,
  input  logic              auto_reload,
  input  logic [WIDE_W-1:0] reload,
  output logic [WIDE_W-1:0] count,
  output logic              term_hit,
  output logic              tc_pulse
);
  localparam logic [WIDE_W-1:0] NARROW_MASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [WIDE_W-1:0] width_mask;
  logic [WIDE_W-1:0] load_mask;
  logic              held_q;
  logic              at_term;

  assign width_mask = wide      ? '1 : NARROW_MASK;
  assign load_mask  = load_wide ? '1 : NARROW_MASK;
  assign at_term    = count_down ? (count == '0) : (count == width_mask);
  assign term_hit   = step & ~held_q & ~load_start & at_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      held_q   <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= 1'b0;
      if (load_start) begin
        count  <= load_down ? (reload & load_mask) : '0;
        held_q <= 1'b0;
      end else if (step && !held_q) begin
        if (at_term) begin
          tc_pulse <= 1'b1;
          if (auto_reload) count  <= reload & width_mask;
          else             held_q <= 1'b1;
        end else if (count_down) begin
          count <= count - 1'b1;
        end else begin
          count <= (count + 1'b1) & width_mask;
        end
      end
    end
  end

  // R9: a channel that has stopped at its terminal value keeps that value
  a_r9_held_stable: assert property (@(posedge clk) disable iff (rst)
    (held_q && !load_start) |=> $stable(count));
  // R8: a narrow load never sets bits above the narrow width
  a_r8_narrow_load: assert property (@(posedge clk) disable iff (rst)
    (load_start && !load_wide) |=> ((count & ~NARROW_MASK) == '0));
  // R10: the terminal pulse follows a qualified step
  a_r10_tc_after_step: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> $past(step));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned WIDE_W   = 32,
  parameter int unsigned BUS_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              reload_we,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              ext_event_i,
  input  logic              ext_gate_i,
  input  logic              dbg_halt_i,
  input  logic              lower_tc_i,
  output logic [15:0]       ctrl_o,
  output logic [WIDE_W-1:0] reload_o,
  output logic [WIDE_W-1:0] count_o,
  output logic              tc_o,
  output logic              irq_o
);
  tmr_ctrl_t         ctrl_q;
  tmr_ctrl_t         ctrl_new;
  logic [WIDE_W-1:0] reload_q;
  logic              load_start;
  logic              irq_clr;
  logic              pre_tick;
  logic              step;
  logic              term_hit;
  logic [1:0]        pins_s;

  assign ctrl_new   = ctrl_decode(wdata[15:0]);
  assign load_start = ctrl_we & ctrl_new.run & ~ctrl_q.run;
  assign irq_clr    = ctrl_we & wdata[CTL_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_we)   ctrl_q   <= ctrl_new;
      if (reload_we) reload_q <= wdata[WIDE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            irq_o <= 1'b0;
    else if (irq_clr)                   irq_o <= 1'b0;
    else if (term_hit && ctrl_q.irq_en) irq_o <= 1'b1;
  end

  tmr_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_gate_i, ext_event_i}),
    .q   (pins_s)
  );

  tmr_prescale u_pre (
    .clk   (clk),
    .rst   (rst),
    .clear (load_start),
    .run   (ctrl_q.run),
    .sel   (ctrl_q.clk_sel),
    .tick  (pre_tick)
  );

  tmr_tick_sel u_sel (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl_q),
    .pre_tick (pre_tick),
    .ext_s    (pins_s[0]),
    .gate_s   (pins_s[1]),
    .lower_tc (lower_tc_i),
    .dbg_halt (dbg_halt_i),
    .step     (step)
  );

  tmr_counter #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .load_start  (load_start),
    .load_down   (ctrl_new.count_down),
    .load_wide   (ctrl_new.wide),
    .step        (step),
    .count_down  (ctrl_q.count_down),
    .wide        (ctrl_q.wide),
    .auto_reload (ctrl_q.auto_reload),
    .reload      (reload_q),
    .count       (count_o),
    .term_hit    (term_hit),
    .tc_pulse    (tc_o)
  );

  assign ctrl_o   = ctrl_encode(ctrl_q);
  assign reload_o = reload_q;

  // R11: a clear write always leaves the flag low, even against a same-cycle set
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> !irq_o);
  // R11: the flag stays set until it is cleared
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o);
  // R3: a stopped channel keeps its count unless the control word is written
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !ctrl_we) |=> $stable(count_o));
  // R13: the debug freeze holds the count
  a_r13_dbg_freeze: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && ctrl_q.dbg_freeze && dbg_halt_i && !ctrl_we) |=> $stable(count_o));
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NW = 4;
  localparam int  WW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctrl_we = 1'b0, reload_we = 1'b0;
  logic [31:0]   wdata = '0;
  logic          ext_event_i = 1'b0, ext_gate_i = 1'b0, dbg_halt_i = 1'b0, lower_tc_i = 1'b0;
  logic [15:0]   ctrl_o;
  logic [WW-1:0] reload_o, count_o;
  logic          tc_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_channel #(.NARROW_W(NW), .WIDE_W(WW), .BUS_W(32)) dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .reload_we(reload_we), .wdata(wdata),
    .ext_event_i(ext_event_i), .ext_gate_i(ext_gate_i), .dbg_halt_i(dbg_halt_i),
    .lower_tc_i(lower_tc_i), .ctrl_o(ctrl_o), .reload_o(reload_o), .count_o(count_o),
    .tc_o(tc_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit run, input bit dbgf, input bit clr,
                                     input logic [2:0] sel, input logic [1:0] mode,
                                     input bit ie, input bit dn, input bit wd, input bit rl);
    return {run, 4'b0000, dbgf, clr, sel, mode, ie, dn, wd, rl};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_we = 1'b1; wdata = {16'h0, v};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_reload(input logic [31:0] v);
    reload_we = 1'b1; wdata = v;
    @(negedge clk);
    reload_we = 1'b0;
  endtask

  // Stop the channel (clearing any interrupt), then enable it again.
  task automatic start(input logic [15:0] c);
    wr_ctrl((c & 16'h7FFF) | 16'h0200);
    wr_ctrl(c | 16'h8000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [WW-1:0] v;
    step(3);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk("R1 count", 32'(count_o), 0);
    chk("R1 ctrl", 32'(ctrl_o), 0);
    chk("R1 reload", 32'(reload_o), 0);
    chk("R1 tc/irq", {30'b0, tc_o, irq_o}, 0);

    // R2 field readback
    wr_ctrl(16'hFFFF);
    chk("R2 ctrl readback", 32'(ctrl_o), 32'h85FF);
    wr_reload(32'h1234_56AB);
    chk("R2 reload readback", 32'(reload_o), 32'hAB);

    // R8 masking of the loaded reload value; R3 down-count load
    start(cw(1, 0, 0, 3'd0, 2'd0, 0, 1, 0, 1));
    chk("R8 narrow load masked", 32'(count_o), 32'hB);
    start(cw(1, 0, 0, 3'd0, 2'd0, 0, 1, 1, 1));
    chk("R3 wide down load", 32'(count_o), 32'hAB);

    // R4 divide sweep: first advance at 2^k, rate 1/2^k
    for (int k = 0; k < 7; k++) begin
      start(cw(1, 0, 0, 3'(k), 2'd0, 0, 0, 1, 0));
      chk("R3 up load zero", 32'(count_o), 0);
      if (k > 0) begin
        step((1 << k) - 1);
        chk($sformatf("R4 code %0d before first", k), 32'(count_o), 0);
        step(1);
      end else step(1);
      chk($sformatf("R4 code %0d first", k), 32'(count_o), 1);
      step(150 - (1 << k));
      chk($sformatf("R4 code %0d rate", k), 32'(count_o), 150 >> k);
    end

    // R3 disabling freezes
    wr_ctrl(cw(0, 0, 0, 3'd0, 2'd0, 0, 0, 1, 0));
    v = count_o;
    step(10);
    chk("R3 disabled hold", 32'(count_o), 32'(v));

    // R7 R9 R10 R11 down with reload 5, narrow
    wr_reload(32'd5);
    start(cw(1, 0, 0, 3'd0, 2'd0, 1, 1, 0, 1));
    for (int n = 1; n <= 20; n++) begin
      step(1);
      chk($sformatf("R7 down n=%0d", n), 32'(count_o), 5 - (n % 6));
      chk($sformatf("R10 tc n=%0d", n), 32'(tc_o), (n % 6 == 0) ? 1 : 0);
    end
    chk("R11 irq set", 32'(irq_o), 1);
    wr_ctrl(cw(1, 0, 1, 3'd0, 2'd0, 1, 1, 0, 1));
    chk("R11 irq cleared", 32'(irq_o), 0);

    // R11 clear wins on the terminal cycle
    wr_reload(32'd3);
    start(cw(1, 0, 0, 3'd0, 2'd0, 1, 1, 0, 1));
    step(3);
    chk("R7 reached zero", 32'(count_o), 0);
    wr_ctrl(cw(1, 0, 1, 3'd0, 2'd0, 1, 1, 0, 1));
    chk("R10 tc on clear cycle", 32'(tc_o), 1);
    chk("R11 clear wins", 32'(irq_o), 0);
    chk("R9 reload after term", 32'(count_o), 3);
    step(4);
    chk("R11 irq set again", 32'(irq_o), 1);

    // R7 R9 up narrow, no reload: hold and stop
    start(cw(1, 0, 0, 3'd0, 2'd0, 0, 0, 0, 0));
    step(15);
    chk("R7 up narrow top", 32'(count_o), 15);
    step(1);
    chk("R9 hold at term", 32'(count_o), 15);
    chk("R10 tc up", 32'(tc_o), 1);
    step(4);
    chk("R9 stays stopped", 32'(count_o), 15);
    chk("R10 tc single", 32'(tc_o), 0);
    start(cw(1, 0, 0, 3'd0, 2'd0, 0, 0, 0, 0));
    step(3);
    chk("R9 restart", 32'(count_o), 3);

    // R8 up wide terminal at 255
    start(cw(1, 0, 0, 3'd0, 2'd0, 0, 0, 1, 0));
    step(255);
    chk("R8 wide top", 32'(count_o), 255);
    step(1);
    chk("R8 wide term tc", 32'(tc_o), 1);

    // R9 up narrow with reload 12
    wr_reload(32'd12);
    start(cw(1, 0, 0, 3'd0, 2'd0, 0, 0, 0, 1));
    step(15);
    for (int n = 16; n <= 23; n++) begin
      step(1);
      chk($sformatf("R9 up reload n=%0d", n), 32'(count_o), 12 + ((n - 16) % 4));
    end

    // R5 external events
    start(cw(1, 0, 0, 3'd7, 2'd0, 0, 0, 1, 0));
    for (int i = 0; i < 10; i++) begin
      ext_event_i = 1'b1; step(2);
      ext_event_i = 1'b0; step(2);
    end
    step(4);
    chk("R5 event count", 32'(count_o), 10);
    ext_event_i = 1'b1; step(20);
    ext_event_i = 1'b0; step(4);
    chk("R5 held level one event", 32'(count_o), 11);

    // R6 gate high
    ext_gate_i = 1'b0; step(3);
    start(cw(1, 0, 0, 3'd0, 2'd2, 0, 0, 1, 0));
    step(20);
    chk("R6 gate hi closed", 32'(count_o), 0);
    ext_gate_i = 1'b1; step(30);
    ext_gate_i = 1'b0; step(10);
    chk("R6 gate hi count", 32'(count_o), 30);
    // R6 gate low
    ext_gate_i = 1'b1; step(3);
    start(cw(1, 0, 0, 3'd0, 2'd1, 0, 0, 1, 0));
    step(20);
    chk("R6 gate lo closed", 32'(count_o), 0);
    ext_gate_i = 1'b0; step(25);
    ext_gate_i = 1'b1; step(10);
    chk("R6 gate lo count", 32'(count_o), 25);
    ext_gate_i = 1'b0;

    // R12 chain mode ignores clock select
    start(cw(1, 0, 0, 3'd0, 2'd3, 0, 0, 1, 0));
    step(20);
    chk("R12 idle chain", 32'(count_o), 0);
    for (int i = 0; i < 7; i++) begin
      lower_tc_i = 1'b1; step(1);
      lower_tc_i = 1'b0; step(1);
    end
    step(2);
    chk("R12 chain count", 32'(count_o), 7);

    // R13 debug freeze on / off
    start(cw(1, 1, 0, 3'd0, 2'd0, 0, 0, 1, 0));
    step(10); dbg_halt_i = 1'b1; step(10); dbg_halt_i = 1'b0; step(10);
    chk("R13 frozen", 32'(count_o), 20);
    start(cw(1, 0, 0, 3'd0, 2'd0, 0, 0, 1, 0));
    step(10); dbg_halt_i = 1'b1; step(10); dbg_halt_i = 1'b0; step(10);
    chk("R13 no freeze", 32'(count_o), 30);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule